// File: doc/BRIEF.md
# Receive Buffer with Hold-Watermark Throttle

This block sits on the receive side of a serial storage link. It stores incoming 32-bit words in a 128-entry buffer. A consumer drains the words through a ready/valid handshake. When free space falls under a programmable watermark, the block raises `hold` to ask the far end to pause. It then counts how many words still arrive before the far end answers on `holda`.

The watermark is chosen by bit 2 of an 8-bit configuration byte. With that bit clear, the threshold is 32 free words. With it set, the threshold is 64 free words, which gives room for senders that keep transmitting for up to 40 words after being asked to pause. `hold` drops again once free space has climbed 8 words past the threshold.

A word that arrives while the buffer is full and no read frees a slot is an overflow. It aborts the transfer: `rx_err` goes high and stays high, and every later word is dropped. This lasts until the synchronous `clr` input empties the buffer.

Top module: `rx_hold_fifo`

## Requirements
- R1: Words written with `in_valid` leave in arrival order. `out_valid` is high whenever the buffer holds at least one word, and a word is removed in each cycle where `out_valid` and `out_ready` are both high.
- R2: A write and a read in the same cycle leave the occupancy unchanged. When the buffer is full, this combination raises no error.
- R3: With configuration bit 2 at 0, `hold` goes high on the clock edge after free space (128 minus occupancy) has dropped below 32.
- R4: With configuration bit 2 at 1, the threshold is 64 free words. A burst of 40 words after `hold` then completes without error.
- R5: Once high, `hold` stays high until free space reaches the threshold plus 8. It goes low on the clock edge after that.
- R6: A write into a full buffer with no read in the same cycle drops the word and sets `rx_err`, which stays high.
- R7: While `rx_err` is high, writes are ignored and the stored words can still be read out.
- R8: Asserting `clr` for one cycle empties the buffer and clears `rx_err`, `hold` and `slack_cnt`. It keeps the configuration byte.
- R9: The configuration byte is stored on `cfg_we` and reads back on `cfg_q`. It resets to 0. Bits other than bit 2 have no effect on the throttle.
- R10: `slack_cnt` restarts at 0 when `hold` rises. It then counts the words accepted while `hold` is high, before `holda` arrives. It saturates at 255 and stops once `holda` has been seen.
- R11: After reset the buffer is empty, and `hold`, `rx_err` and `slack_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of buffer and error |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte value; bit 2 selects the high watermark |
| cfg_q | output | 8 | Stored configuration byte |
| in_valid | input | 1 | Incoming word strobe |
| in_data | input | 32 | Incoming word |
| out_valid | output | 1 | Buffer not empty |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | 32 | Head word |
| hold | output | 1 | Pause request to the far end |
| holda | input | 1 | Pause acknowledgement from the far end |
| rx_err | output | 1 | Overflow abort flag |
| slack_cnt | output | 8 | Words accepted between hold and acknowledgement |

## Verification
The bench builds the block with its defaults: 128 words of depth, marks of 32 and 64, and 8 words of hysteresis. At these sizes every boundary can be reached within a few hundred cycles. A 40-word burst after `hold` overflows the buffer under the low mark and fits under the high mark. The full boundary can be driven with simultaneous reads and writes, and both edges of the hysteresis band can be sampled while draining.

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int W       = 32,
  parameter int DEPTH   = 128,
  parameter int LO_MARK = 32,
  parameter int HI_MARK = 64,
  parameter int HYST    = 8,
  parameter int SEL_BIT = 2,
  parameter int SW      = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         cfg_we,
  input  logic [7:0]   cfg_wdata,
  output logic [7:0]   cfg_q,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         hold,
  input  logic         holda,
  output logic         rx_err,
  output logic [SW-1:0] slack_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          ack;

  wire           full     = count == CW'(DEPTH);
  wire           pop      = out_valid && out_ready;
  wire           push     = in_valid && !rx_err && (!full || pop);
  wire           ovf      = in_valid && !rx_err && full && !pop;
  wire [CW-1:0]  free     = CW'(DEPTH) - count;
  wire [CW-1:0]  thr      = cfg_q[SEL_BIT] ? CW'(HI_MARK) : CW'(LO_MARK);
  wire           hold_nxt = hold ? (free < thr + CW'(HYST)) : (free < thr);

  assign out_valid = count != '0;
  assign out_data  = mem[rp];

  always_ff @(posedge clk)
    if (push) mem[wp] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (cfg_we)
      cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
      hold <= 1'b0; ack <= 1'b0; rx_err <= 1'b0; slack_cnt <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
      hold <= 1'b0; ack <= 1'b0; rx_err <= 1'b0; slack_cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count  <= count + CW'(push) - CW'(pop);
      rx_err <= rx_err | ovf;
      hold   <= hold_nxt;
      ack    <= hold_nxt && (ack || (hold && holda));
      if (!hold && hold_nxt)
        slack_cnt <= '0;
      else if (hold && !ack && !holda && push && slack_cnt != '1)
        slack_cnt <= slack_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_hold_fifo_chk.sv
module rx_hold_fifo_chk #(
  parameter int DEPTH   = 128,
  parameter int LO_MARK = 32,
  parameter int HI_MARK = 64,
  parameter int HYST    = 8,
  parameter int SEL_BIT = 2,
  parameter int CW      = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          in_valid,
  input logic          out_valid,
  input logic          out_ready,
  input logic          hold,
  input logic          rx_err,
  input logic [7:0]    cfg_q,
  input logic [CW-1:0] count
);
  int free_w, thr_w;
  always_comb begin
    free_w = DEPTH - int'(count);
    thr_w  = cfg_q[SEL_BIT] ? HI_MARK : LO_MARK;
  end

  assert_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  assert_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid && !clr) |=> count == $past(count) - 1'b1);

  assert_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_valid && !rx_err && !clr) |=> count == $past(count));

  assert_hold_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !clr && free_w < thr_w) |=> hold);

  assert_hold_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr && free_w >= thr_w + HYST) |=> !hold);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !clr) |=> rx_err);

  assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !clr) |=> count <= $past(count));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !rx_err && !hold));
endmodule

bind rx_hold_fifo rx_hold_fifo_chk #(
  .DEPTH(DEPTH), .LO_MARK(LO_MARK), .HI_MARK(HI_MARK),
  .HYST(HYST), .SEL_BIT(SEL_BIT), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
  .out_valid(out_valid), .out_ready(out_ready), .hold(hold),
  .rx_err(rx_err), .cfg_q(cfg_q), .count(count)
);

// File: tb/rx_hold_fifo_bench.sv
module rx_hold_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_q;
  logic        in_valid = 1'b0, out_ready = 1'b0, holda = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid, hold, rx_err;
  logic [31:0] out_data;
  logic [7:0]  slack_cnt;

  int checks = 0, errors = 0, seq = 0;
  bit started = 0;

  always #5 clk = ~clk;

  rx_hold_fifo u_rx_hold_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .hold(hold), .holda(holda),
    .rx_err(rx_err), .slack_cnt(slack_cnt)
  );

  // behavioural reference
  logic [31:0] q[$];
  bit   mh, ma, me, nh, pop, wr, full;
  int   ms, free, thr, sz;
  logic [7:0] mc;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mh = 0; ma = 0; me = 0; ms = 0; mc = 0;
    end else begin
      sz   = q.size();
      free = 128 - sz;
      thr  = mc[2] ? 64 : 32;
      nh   = mh ? (free < thr + 8) : (free < thr);
      pop  = out_ready && sz > 0;
      full = sz == 128;
      if (clr) begin
        q.delete(); mh = 0; ma = 0; me = 0; ms = 0;
      end else begin
        wr = in_valid && !me && (!full || pop);
        if (in_valid && !me && full && !pop) me = 1;
        if (!mh && nh) ms = 0;
        else if (mh && !ma && !holda && wr && ms < 255) ms++;
        if (!nh) ma = 0;
        else if (mh && holda) ma = 1;
        if (pop) void'(q.pop_front());
        if (wr) q.push_back(in_data);
        mh = nh;
      end
      if (cfg_we) mc = cfg_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    check(out_valid == (q.size() > 0), "R1 out_valid", out_valid, q.size() > 0);
    if (q.size() > 0) check(out_data == q[0], "R1 out_data", out_data, q[0]);
    check(hold == mh, "R3 R4 R5 hold", hold, mh);
    check(rx_err == me, "R6 R7 rx_err", rx_err, me);
    check(slack_cnt == 8'(ms), "R10 slack_cnt", slack_cnt, ms);
    check(cfg_q == mc, "R9 cfg_q", cfg_q, mc);
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_n(input int n, input bit rd);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = 32'hA500_0000 + 32'(seq); seq++; out_ready = rd;
      step();
    end
    in_valid = 0; out_ready = 0;
  endtask

  task automatic rd_n(input int n);
    for (int i = 0; i < n; i++) begin
      out_ready = 1; step();
    end
    out_ready = 0;
  endtask

  task automatic drain(output int n);
    n = 0;
    while (out_valid) begin
      out_ready = 1; step(); n++;
    end
    out_ready = 0;
  endtask

  task automatic do_clr();
    clr = 1; step(); clr = 0; step();
  endtask

  task automatic set_cfg(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v; step(); cfg_we = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    started = 1;
    step(); step();
    // R11 reset state
    check(!out_valid && !hold && !rx_err && slack_cnt == 0, "R11 reset", {out_valid, hold, rx_err}, 0);
    check(cfg_q == 8'h00, "R9 reset cfg", cfg_q, 0);
    rst_n = 1; step();

    // R1 ordering with interleaved reads
    wr_n(10, 0);
    for (int i = 0; i < 6; i++) begin wr_n(1, i % 2); end
    drain(n);
    check(n == 13, "R1 drained count", n, 13);

    // R3, R10, R5 on the low mark
    wr_n(96, 0);
    check(!hold, "R3 no hold at 32 free", hold, 0);
    wr_n(1, 0); wr_n(5, 0);
    check(hold, "R3 hold at 31 free", hold, 1);
    check(slack_cnt == 4, "R10 slack", slack_cnt, 4);
    holda = 1; step(); holda = 0;
    wr_n(3, 0);
    check(slack_cnt == 4, "R10 stops after holda", slack_cnt, 4);
    rd_n(13);
    check(hold, "R5 hysteresis keeps hold", hold, 1);
    rd_n(13);
    check(!hold, "R5 hold released", hold, 0);
    do_clr();

    // R6, R7, R8 overflow under the low mark
    wr_n(137, 0);
    check(rx_err, "R6 overflow sets error", rx_err, 1);
    wr_n(5, 0);
    drain(n);
    check(n == 128, "R7 writes ignored after error", n, 128);
    check(rx_err, "R6 error sticky", rx_err, 1);
    wr_n(2, 0);
    check(!out_valid, "R7 no write while error", out_valid, 0);
    set_cfg(8'hA4);
    wr_n(50, 0);
    do_clr();
    check(!rx_err && !out_valid && !hold && slack_cnt == 0, "R8 clear", {rx_err, out_valid, hold}, 0);
    check(cfg_q == 8'hA4, "R8 cfg kept", cfg_q, 8'hA4);

    // R4 high mark
    wr_n(64, 0); step();
    check(!hold, "R4 no hold at 64 free", hold, 0);
    wr_n(1, 0); step();
    check(hold, "R4 hold at 63 free", hold, 1);
    wr_n(40, 0);
    check(!rx_err, "R4 40-word burst absorbed", rx_err, 0);
    drain(n);
    check(n == 105, "R4 all words kept", n, 105);

    // R9 other bits ignored
    set_cfg(8'hFB);
    check(cfg_q == 8'hFB, "R9 stored", cfg_q, 8'hFB);
    wr_n(96, 0); step();
    check(!hold, "R9 low mark in use", hold, 0);
    wr_n(1, 0); step();
    check(hold, "R9 low mark in use", hold, 1);
    drain(n);

    // R2 simultaneous access at full
    wr_n(128, 0);
    check(!rx_err, "R2 full without error", rx_err, 0);
    wr_n(20, 1);
    check(!rx_err, "R2 read and write at full", rx_err, 0);
    drain(n);
    check(n == 128, "R2 occupancy kept", n, 128);

    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule